// File: doc/BRIEF.md
# Bus Clock Divider with Power-Reset Startup Stretch

This block produces the bus clock for a small processor core and its peripherals. Two source clocks arrive as single-cycle tick strobes in the reference-clock domain. One comes from an external oscillator and the other from an on-chip generator. A select input picks which strobe drives the divider. A chain of divide-by-two stages, two by default, turns the selected ticks into a bus clock at one quarter of the source rate. A one-cycle enable strobe marks each rising edge of that bus clock, so logic on the fast reference clock can advance in step with the bus.

A power-on request or a low-voltage request starts the startup sequence. The two requests are combined and synchronised to the reference clock. While a request is present, and for a fixed stretch of reference-clock cycles after it clears, the block drives its active-low reset output low and holds the divider at zero. Once the stretch counter reaches its terminal value, the reset output rises and the bus clock starts from a known phase. A fresh request at any point restarts the sequence.

There is no data stream through this block. All pins are plain level or strobe controls, and none of them carries a valid/ready handshake or back-pressure.

Top module: `bus_clk_sequencer`

## Requirements
- R1: When `src_sel` is 1 the divider advances only on `int_tick`; when it is 0 it advances only on `ext_tick`. The unselected strobe has no effect on `bus_clk` or `bus_clk_en`.
- R2: While running, `bus_clk` equals bit 1 of the number of selected ticks seen since release. This gives one full bus-clock period per four selected ticks.
- R3: `bus_clk_en` is high for exactly one reference cycle, in the first cycle in which `bus_clk` is high after being low. It never appears on two consecutive cycles.
- R4: `por_req` and `lvi_req` are ORed and passed through a two-flop synchroniser. `rst_out_n` falls after the third rising clock edge at which a request is sampled high.
- R5: After the request is sampled low at consecutive edges, `rst_out_n` rises after the (2^CNT_W + 2)-th such edge. The stretch counter then holds its terminal value of all ones.
- R6: While `rst_out_n` is low, `bus_clk` and `bus_clk_en` are both low.
- R7: A request that arrives while the stretch is counting clears the counter to zero, so the full stretch starts over once the request drops.
- R8: While `rst_n` is low, `rst_out_n`, `bus_clk` and `bus_clk_en` are low. The synchroniser resets to the requesting state, so release from `rst_n` follows the same timing as a dropped request.
- R9: The divider restarts from zero at every release. The first `bus_clk` rise follows the second selected tick after `rst_out_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_req | input | 1 | Power-on reset request, asynchronous, active high |
| lvi_req | input | 1 | Low-voltage reset request, asynchronous, active high |
| src_sel | input | 1 | Source select: 1 picks the internal generator, 0 the external oscillator |
| ext_tick | input | 1 | One-cycle strobe per external oscillator edge |
| int_tick | input | 1 | One-cycle strobe per internal generator edge |
| bus_clk | output | 1 | Divided bus clock level |
| bus_clk_en | output | 1 | One-cycle strobe on each bus-clock rising edge |
| rst_out_n | output | 1 | Active-low reset to the core, low during the startup stretch |

## Verification
The bench builds the block with `CNT_W = 4`, giving a 16-cycle stretch, and with the default two divider stages and two synchroniser flops. The short stretch lets a single run include many complete release sequences. Those runs cover power-on and low-voltage requests landing mid-count, back-to-back pulses, and long holds. In between, the bench sweeps both select values against tick spacings of one to four cycles while the unselected source receives pseudo-random strobes. It also toggles the select on every cycle, so that every divider phase meets a source change.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  // Default configuration
  localparam int unsigned DEF_CNT_W       = 12;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_DIV_STAGES  = 2;

  // Source selection encoding
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } src_e;

endpackage

// File: rtl/bclk_req_sync.sv
module bclk_req_sync #(
  parameter int unsigned STAGES = bclk_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_out
);

  logic [STAGES-1:0] chain_q;

  // Flops reset to "requesting" so block reset behaves as a power request
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= req_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign req_out = chain_q[STAGES-1];

endmodule

// File: rtl/bclk_startup_timer.sv
module bclk_startup_timer #(
  parameter int unsigned CNT_W = bclk_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TERMINAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (req) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == TERMINAL) done_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = done_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/bclk_src_divider.sv
module bclk_src_divider #(
  parameter int unsigned DIV_STAGES = bclk_pkg::DEF_DIV_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  input  logic ext_tick,
  input  logic int_tick,
  output logic bus_clk,
  output logic bus_en
);

  import bclk_pkg::*;

  localparam int unsigned TOP = DIV_STAGES - 1;

  src_e                  sel_e;
  logic                  tick;
  logic [DIV_STAGES-1:0] stg_q;
  logic [DIV_STAGES-1:0] carry;
  logic                  en_q;

  assign sel_e = src_e'(sel);
  assign tick  = (sel_e == SRC_INT) ? int_tick : ext_tick;

  // Each divide-by-two stage toggles when all stages below it are high
  generate
    for (genvar i = 0; i < DIV_STAGES; i++) begin : g_div
      if (i == 0) begin : g_c0
        assign carry[i] = tick;
      end else begin : g_cn
        assign carry[i] = carry[i-1] & stg_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stg_q[i] <= 1'b0;
        else if (!run)     stg_q[i] <= 1'b0;
        else if (carry[i]) stg_q[i] <= ~stg_q[i];
      end
    end
  endgenerate

  // Strobe coincides with the first high cycle of the top stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (!run) en_q <= 1'b0;
    else           en_q <= carry[TOP] & ~stg_q[TOP];
  end

  assign bus_clk = stg_q[TOP];
  assign bus_en  = en_q;

endmodule

// File: rtl/bus_clk_sequencer.sv
module bus_clk_sequencer #(
  parameter int unsigned CNT_W       = bclk_pkg::DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = bclk_pkg::DEF_SYNC_STAGES,
  parameter int unsigned DIV_STAGES  = bclk_pkg::DEF_DIV_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_req,
  input  logic lvi_req,
  input  logic src_sel,
  input  logic ext_tick,
  input  logic int_tick,
  output logic bus_clk,
  output logic bus_clk_en,
  output logic rst_out_n
);

  logic             req_raw;
  logic             req_s;
  logic             stretch_done;
  logic [CNT_W-1:0] stretch_cnt;
  logic             run;

  assign req_raw = por_req | lvi_req;

  bclk_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (req_raw),
    .req_out (req_s)
  );

  bclk_startup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_s),
    .done  (stretch_done),
    .cnt   (stretch_cnt)
  );

  // Divider stops in the same edge that a synchronised request is seen
  assign run = stretch_done & ~req_s;

  bclk_src_divider #(.DIV_STAGES(DIV_STAGES)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sel      (src_sel),
    .ext_tick (ext_tick),
    .int_tick (int_tick),
    .bus_clk  (bus_clk),
    .bus_en   (bus_clk_en)
  );

  assign rst_out_n = stretch_done;

endmodule

// File: rtl/bus_clk_sequencer_chk.sv
module bus_clk_sequencer_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_sel,
  input logic             ext_tick,
  input logic             int_tick,
  input logic             bus_clk,
  input logic             bus_clk_en,
  input logic             rst_out_n,
  input logic             req_s,
  input logic [CNT_W-1:0] cnt
);

  // R1
  src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && $past(rst_out_n) && (bus_clk != $past(bus_clk)))
      |-> $past(src_sel ? int_tick : ext_tick));

  // R3
  en_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_en |-> bus_clk);

  // R3
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_en |=> !bus_clk_en);

  // R3
  rise_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk) |-> bus_clk_en);

  // R6
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (!bus_clk && !bus_clk_en));

  // R4
  req_drops_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_s |=> !rst_out_n);

  // R7
  req_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_s |=> (cnt == '0));

  // R5
  release_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(cnt) == {CNT_W{1'b1}}));

endmodule

bind bus_clk_sequencer bus_clk_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_sel    (src_sel),
  .ext_tick   (ext_tick),
  .int_tick   (int_tick),
  .bus_clk    (bus_clk),
  .bus_clk_en (bus_clk_en),
  .rst_out_n  (rst_out_n),
  .req_s      (req_s),
  .cnt        (stretch_cnt)
);

// File: tb/bus_clk_sequencer_test.sv
`timescale 1ns/1ps
module bus_clk_sequencer_test;

  localparam int CNT_W   = 4;
  localparam int STRETCH = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_req = 1'b0, lvi_req = 1'b0;
  logic src_sel = 1'b0, ext_tick = 1'b0, int_tick = 1'b0;
  logic bus_clk, bus_clk_en, rst_out_n;

  int errors = 0;
  int checks = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bus_clk_sequencer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .por_req(por_req), .lvi_req(lvi_req),
    .src_sel(src_sel), .ext_tick(ext_tick), .int_tick(int_tick),
    .bus_clk(bus_clk), .bus_clk_en(bus_clk_en), .rst_out_n(rst_out_n)
  );

  // Arithmetic model: request history, low streak, tick count since release
  bit h1 = 1, h2 = 1;
  int streak = 0;
  bit exp_rst = 0, exp_bus = 0, exp_en = 0;
  int k = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 1; h2 = 1; streak = 0; k = 0;
      exp_rst = 0; exp_bus = 0; exp_en = 0;
    end else begin
      bit reqs, run, tick;
      reqs = h2;
      h2 = h1;
      h1 = por_req | lvi_req;
      run  = exp_rst && !reqs;
      tick = src_sel ? int_tick : ext_tick;
      exp_en = run && tick && ((k % 4) == 1);
      if (!run) k = 0;
      else if (tick) k = k + 1;
      exp_bus = k[1];
      if (reqs) streak = 0;
      else if (streak < STRETCH) streak = streak + 1;
      exp_rst = (streak >= STRETCH);
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("R4 R5 R7 R8 rst_out_n", rst_out_n, exp_rst);
      check("R1 R2 R6 R9 bus_clk", bus_clk, exp_bus);
      check("R3 R6 bus_clk_en", bus_clk_en, exp_en);
    end
  end

  logic [7:0] lfsr = 8'hA5;
  int cyc = 0;

  task automatic drive(input int n, input int per, input bit sel_mode, input bit toggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc++;
      if (toggle) src_sel = lfsr[2];
      else        src_sel = sel_mode;
      if (src_sel) begin
        int_tick = ((cyc % per) == 0);
        ext_tick = lfsr[0];
      end else begin
        ext_tick = ((cyc % per) == 0);
        int_tick = lfsr[0];
      end
    end
  endtask

  task automatic pulse(input bit use_lvi, input int len);
    @(negedge clk);
    if (use_lvi) lvi_req = 1'b1; else por_req = 1'b1;
    drive(len, 1, 1'b0, 1'b0);
    @(negedge clk);
    lvi_req = 1'b0; por_req = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs low under block reset
    checks++;
    if (rst_out_n !== 1'b0 || bus_clk !== 1'b0 || bus_clk_en !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset state: actual=%b%b%b expected=000", rst_out_n, bus_clk, bus_clk_en);
    end
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    // R8 R9: release and first bus clock, ticks every cycle
    drive(40, 1, 1'b0, 1'b0);
    // R1 R2 R3: both sources, spacing 1..4, noise on the other source
    for (int s = 0; s < 2; s++)
      for (int p = 1; p <= 4; p++)
        drive(40, p, s[0], 1'b0);
    // R4 R6: single-cycle power request mid-run
    pulse(1'b0, 1);
    drive(10, 1, 1'b1, 1'b0);
    // R7: low-voltage request during the stretch restarts it
    pulse(1'b1, 2);
    drive(40, 2, 1'b1, 1'b0);
    // R4 R5: long hold of both requests
    @(negedge clk); por_req = 1'b1; lvi_req = 1'b1;
    drive(30, 1, 1'b0, 1'b0);
    @(negedge clk); por_req = 1'b0; lvi_req = 1'b0;
    drive(40, 1, 1'b0, 1'b0);
    // R1 R2: select changing every cycle
    drive(200, 1, 1'b0, 1'b1);
    drive(200, 3, 1'b0, 1'b1);
    // R8: block reset mid-run, then release again
    @(negedge clk); rst_n = 1'b0; chk_on = 1'b0;
    @(negedge clk);
    checks++;
    if (rst_out_n !== 1'b0 || bus_clk !== 1'b0 || bus_clk_en !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset state: actual=%b%b%b expected=000", rst_out_n, bus_clk, bus_clk_en);
    end
    @(negedge clk); rst_n = 1'b1; chk_on = 1'b1;
    drive(60, 1, 1'b1, 1'b0);
    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule